// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single host requests into timed bus cycles on an asynchronous NAND flash device with an 8-bit or 16-bit data bus. A host presents one request at a time: a command byte, an address byte or a data transfer (write or read, a single byte or a full host word). The sequencer raises the command-latch or address-latch strobe as the request kind calls for, walks each bus beat through programmed setup, strobe, hold and release phases counted in clock cycles, and for reads returns the sampled device data assembled into a host word.

Two configuration words steer it. A control word carries a soft reset, the chip-enable bank switch, the bus-width select and two read turnaround delays (one used after a command, one after an address). A timing word carries four 8-bit phase lengths. The block reports a busy flag that covers the whole transaction including bus release; requests are only taken while it is low. The configuration is expected to stay constant while busy is high, apart from the soft reset bit.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset busy is low, nWE and nRE are high, CLE, ALE and the data output enable are low, and rd_data is zero.
- R2: nand_ce_n is the inverse of control bit 2 (bank enable); while that bit is clear a request is ignored and busy stays low.
- R3: While control bit 0 (soft reset) is set the sequencer returns to idle on the next clock edge, deasserts its strobes, ignores requests and forgets the kind of the last request, so a following read has no turnaround delay.
- R4: req_kind 2'b00 is a command and holds CLE high, 2'b01 is an address and holds ALE high, for every cycle of the request except the release phase; 2'b10 and 2'b11 are data and raise neither. Commands and addresses are always one write beat driving req_wdata[7:0] on dq[7:0] with dq[15:8] zero, whatever req_write says.
- R5: The timing word holds setup in bits 7:0, wait in bits 15:8, hold in bits 23:16 and release in bits 31:24. A write beat keeps nWE high for setup cycles with data driven, holds nWE low for wait+1 cycles, keeps data driven for hold cycles with nWE high; after the last beat the bus is released (output enable low, busy high) for the release count, which may be zero.
- R6: A setup, wait or hold field programmed as 0 behaves as 1.
- R7: Control bit 4 set selects a 16-bit bus. A data request with req_word set makes 4 byte beats on an 8-bit bus or 2 halfword beats on a 16-bit bus, least significant part first; with req_word clear it makes one beat carrying req_wdata[7:0] with dq[15:8] zero.
- R8: A data request with req_write clear is a read: nRE follows the same phase timing as nWE, the output enable stays low, dq_in is sampled in the last strobe cycle of each beat and packed least significant first into rd_data (only dq[7:0] for 8-bit or single-byte reads, upper bits zero); rd_data is cleared when a read is accepted and holds its value until the next one.
- R9: A read that directly follows a command waits tCLR+1 extra cycles (control bits 12:9) before its setup phase; after an address it waits tAR+1 cycles (control bits 16:13); after a data request it waits none.
- R10: busy rises on the clock edge that accepts a request and falls when the release phase ends; a request presented while busy is high is ignored.
- R11: nWE and nRE are never low together, and the driven data does not change while nWE stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | CTRL_W | Control word: soft reset, bank enable, width, turnaround delays |
| cfg_timing | input | 4*TF_W | Setup, wait, hold and release lengths |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind: command, address or data |
| req_write | input | 1 | Data direction, set for write |
| req_word | input | 1 | Set for a full host word, clear for one byte |
| req_wdata | input | HOST_W | Write data, command or address byte |
| busy | output | 1 | Transaction in progress |
| rd_data | output | HOST_W | Assembled read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data driven toward the device |
| nand_dq_oe | output | 1 | Data output enable |
| nand_dq_in | input | 16 | Data from the device |

## Verification
A wrong phase or beat counter shows up within one transaction as a busy window, strobe-low count or setup-before-strobe count that differs from the sum computed from the timing fields, so every request is measured cycle by cycle at the pins. A lost record of the previous request kind shows only on the next read, as a missing or spurious turnaround gap, which is why reads are placed directly after commands, addresses, data transfers and a soft reset. Beat ordering errors appear as swapped bytes in the captured write beats or in rd_data as soon as a multi-beat request completes.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   localparam int DQ_W = 16;

   // control word bit map (fields decoded by the sequencer)
   localparam int CTL_SRST     = 0;
   localparam int CTL_BANK     = 2;
   localparam int CTL_WIDE     = 4;
   localparam int CTL_TCLR_LSB = 9;
   localparam int CTL_TAR_LSB  = 13;

   // field order inside the timing word
   localparam int TIM_SETUP = 0;
   localparam int TIM_WAIT  = 1;
   localparam int TIM_HOLD  = 2;
   localparam int TIM_HIZ   = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_TURN,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_HIZ
   } phase_e;

   typedef enum logic [1:0] {
      RK_CMD  = 2'b00,
      RK_ADDR = 2'b01,
      RK_DATA = 2'b10,
      RK_DAT2 = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      LK_NONE,
      LK_CMD,
      LK_ADDR
   } last_kind_e;

endpackage

// File: rtl/nand_cfg_decode.sv
module nand_cfg_decode
   import nand_seq_pkg::*;
#(
   parameter int CTRL_W = 32,
   parameter int TF_W   = 8,
   parameter int TD_W   = 4,
   localparam int CNT_W = TF_W + 1
) (
   input  logic [CTRL_W-1:0] ctrl,
   input  logic [4*TF_W-1:0] timing,
   output logic              srst,
   output logic              bank_en,
   output logic              wide,
   output logic [CNT_W-1:0]  setup_len,
   output logic [CNT_W-1:0]  strobe_len,
   output logic [CNT_W-1:0]  hold_len,
   output logic [CNT_W-1:0]  hiz_len,
   output logic [CNT_W-1:0]  clr_len,
   output logic [CNT_W-1:0]  ar_len
);

   if (CTL_TAR_LSB + TD_W > CTRL_W) begin : g_bad_ctrl
      $error("control word too narrow for the turnaround fields");
   end
   if (TD_W >= CNT_W) begin : g_bad_td
      $error("turnaround field must be narrower than the phase counter");
   end

   function automatic logic [CNT_W-1:0] at_least_one(input logic [TF_W-1:0] f);
      return (f == '0) ? CNT_W'(1) : {1'b0, f};
   endfunction

   logic [TF_W-1:0] f_setup, f_wait, f_hold, f_hiz;
   logic [TD_W-1:0] f_tclr, f_tar;

   assign f_setup = timing[TIM_SETUP*TF_W +: TF_W];
   assign f_wait  = timing[TIM_WAIT*TF_W  +: TF_W];
   assign f_hold  = timing[TIM_HOLD*TF_W  +: TF_W];
   assign f_hiz   = timing[TIM_HIZ*TF_W   +: TF_W];
   assign f_tclr  = ctrl[CTL_TCLR_LSB +: TD_W];
   assign f_tar   = ctrl[CTL_TAR_LSB  +: TD_W];

   assign srst    = ctrl[CTL_SRST];
   assign bank_en = ctrl[CTL_BANK];
   assign wide    = ctrl[CTL_WIDE];

   assign setup_len  = at_least_one(f_setup);
   assign strobe_len = at_least_one(f_wait) + CNT_W'(1);
   assign hold_len   = at_least_one(f_hold);
   assign hiz_len    = {1'b0, f_hiz};
   assign clr_len    = CNT_W'(f_tclr) + CNT_W'(1);
   assign ar_len     = CNT_W'(f_tar) + CNT_W'(1);

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^{ctrl[1], ctrl[3], ctrl[CTRL_W-1:CTL_WIDE+1]};

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_len,
   output logic             expire
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_len - CNT_W'(1);
      end else if (remain != '0) begin
         remain <= remain - CNT_W'(1);
      end
   end

   assign expire = (remain == '0);

   // R6
   len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_len != '0));

endmodule

// File: rtl/nand_lane_io.sv
module nand_lane_io
   import nand_seq_pkg::*;
#(
   parameter int HOST_W = 32,
   localparam int NB     = HOST_W / 8,
   localparam int BEAT_W = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic              wide,
   input  logic              narrow,
   input  logic [BEAT_W-1:0] beat,
   input  logic [HOST_W-1:0] wdata,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_word,
   output logic [HOST_W-1:0] rd_data
);

   logic              halfword;
   logic [7:0]        wbytes [NB];
   logic [BEAT_W-1:0] lo_idx, hi_idx;

   assign halfword = wide && !narrow;
   assign lo_idx   = halfword ? {beat[BEAT_W-2:0], 1'b0} : beat;
   assign hi_idx   = {beat[BEAT_W-2:0], 1'b1};
   assign dq_word  = {halfword ? wbytes[hi_idx] : 8'h00, wbytes[lo_idx]};

   for (genvar j = 0; j < NB; j++) begin : g_lane
      localparam int HALF = j / 2;
      localparam int SUB  = j % 2;
      logic       hit;
      logic [7:0] src;

      assign wbytes[j] = wdata[8*j +: 8];
      assign hit = halfword ? (beat == BEAT_W'(HALF)) : (beat == BEAT_W'(j));
      assign src = halfword ? dq_in[8*SUB +: 8] : dq_in[7:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data[8*j +: 8] <= '0;
         end else if (clear) begin
            rd_data[8*j +: 8] <= '0;
         end else if (capture && hit) begin
            rd_data[8*j +: 8] <= src;
         end
      end
   end

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int HOST_W = 32,
   parameter int TF_W   = 8,
   parameter int TD_W   = 4,
   parameter int CTRL_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] cfg_ctrl,
   input  logic [4*TF_W-1:0] cfg_timing,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_write,
   input  logic              req_word,
   input  logic [HOST_W-1:0] req_wdata,
   output logic              busy,
   output logic [HOST_W-1:0] rd_data,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [15:0]       nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [15:0]       nand_dq_in
);

   localparam int NB     = HOST_W / 8;
   localparam int BEAT_W = $clog2(NB);
   localparam int CNT_W  = TF_W + 1;

   if ((HOST_W % 16) != 0 || HOST_W < 32) begin : g_bad_host
      $error("host word must be a multiple of 16 bits and at least 32");
   end

   // configuration decode
   logic             srst, bank_en, wide;
   logic [CNT_W-1:0] setup_len, strobe_len, hold_len, hiz_len, clr_len, ar_len;

   nand_cfg_decode #(.CTRL_W(CTRL_W), .TF_W(TF_W), .TD_W(TD_W)) u_cfg (
      .ctrl       (cfg_ctrl),
      .timing     (cfg_timing),
      .srst       (srst),
      .bank_en    (bank_en),
      .wide       (wide),
      .setup_len  (setup_len),
      .strobe_len (strobe_len),
      .hold_len   (hold_len),
      .hiz_len    (hiz_len),
      .clr_len    (clr_len),
      .ar_len     (ar_len)
   );

   // sequencer state
   phase_e            ph, ph_nxt;
   logic [1:0]        cur_kind;
   last_kind_e        last_kind;
   logic              cur_write, cur_narrow, cur_wide;
   logic [BEAT_W-1:0] beat, last_beat;
   logic              t_load, t_done;
   logic [CNT_W-1:0]  t_len;

   logic req_is_data, req_is_read, accept, need_turn, at_last;
   logic [CNT_W-1:0] turn_len;

   assign req_is_data = req_kind[1];
   assign req_is_read = req_is_data && !req_write;
   assign busy        = (ph != PH_IDLE);
   assign accept      = req_valid && !busy && bank_en && !srst;
   assign need_turn   = req_is_read && (last_kind != LK_NONE);
   assign turn_len    = (last_kind == LK_CMD) ? clr_len : ar_len;
   assign last_beat   = cur_narrow ? '0 :
                        cur_wide   ? BEAT_W'(NB/2 - 1) : BEAT_W'(NB - 1);
   assign at_last     = (beat == last_beat);

   nand_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_len (t_len),
      .expire   (t_done)
   );

   always_comb begin
      ph_nxt = ph;
      t_load = 1'b0;
      t_len  = setup_len;
      unique case (ph)
         PH_IDLE: begin
            if (accept) begin
               t_load = 1'b1;
               if (need_turn) begin
                  ph_nxt = PH_TURN;
                  t_len  = turn_len;
               end else begin
                  ph_nxt = PH_SETUP;
               end
            end
         end
         PH_TURN: begin
            if (t_done) begin
               ph_nxt = PH_SETUP;
               t_load = 1'b1;
            end
         end
         PH_SETUP: begin
            if (t_done) begin
               ph_nxt = PH_STROBE;
               t_load = 1'b1;
               t_len  = strobe_len;
            end
         end
         PH_STROBE: begin
            if (t_done) begin
               ph_nxt = PH_HOLD;
               t_load = 1'b1;
               t_len  = hold_len;
            end
         end
         PH_HOLD: begin
            if (t_done) begin
               if (!at_last) begin
                  ph_nxt = PH_SETUP;
                  t_load = 1'b1;
               end else if (hiz_len == '0) begin
                  ph_nxt = PH_IDLE;
               end else begin
                  ph_nxt = PH_HIZ;
                  t_load = 1'b1;
                  t_len  = hiz_len;
               end
            end
         end
         PH_HIZ: begin
            if (t_done) ph_nxt = PH_IDLE;
         end
         default: ph_nxt = PH_IDLE;
      endcase
      if (srst) begin
         ph_nxt = PH_IDLE;
         t_load = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         cur_kind   <= RK_CMD;
         cur_write  <= 1'b0;
         cur_narrow <= 1'b1;
         cur_wide   <= 1'b0;
         beat       <= '0;
         last_kind  <= LK_NONE;
      end else begin
         ph <= ph_nxt;
         if (srst) begin
            last_kind <= LK_NONE;
            beat      <= '0;
         end else if (accept) begin
            cur_kind   <= req_kind;
            cur_write  <= req_is_data ? req_write : 1'b1;
            cur_narrow <= !req_is_data || !req_word;
            cur_wide   <= wide;
            beat       <= '0;
            last_kind  <= (req_kind == RK_CMD)  ? LK_CMD :
                          (req_kind == RK_ADDR) ? LK_ADDR : LK_NONE;
         end else if (ph == PH_HOLD && t_done && !at_last) begin
            beat <= beat + BEAT_W'(1);
         end
      end
   end

   // data lanes
   logic [15:0] dq_word;
   logic        rd_clear, rd_capture;

   assign rd_clear   = accept && req_is_read;
   assign rd_capture = (ph == PH_STROBE) && t_done && !cur_write && !srst;

   nand_lane_io #(.HOST_W(HOST_W)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (rd_clear),
      .capture (rd_capture),
      .wide    (cur_wide),
      .narrow  (cur_narrow),
      .beat    (beat),
      .wdata   (req_wdata),
      .dq_in   (nand_dq_in),
      .dq_word (dq_word),
      .rd_data (rd_data)
   );

   // pin decode
   logic in_cycle, drive;

   assign in_cycle    = busy && (ph != PH_HIZ);
   assign drive       = cur_write && (ph == PH_SETUP || ph == PH_STROBE || ph == PH_HOLD);
   assign nand_ce_n   = !bank_en;
   assign nand_cle    = in_cycle && (cur_kind == RK_CMD);
   assign nand_ale    = in_cycle && (cur_kind == RK_ADDR);
   assign nand_we_n   = !((ph == PH_STROBE) && cur_write);
   assign nand_re_n   = !((ph == PH_STROBE) && !cur_write);
   assign nand_dq_oe  = drive;
   assign nand_dq_out = drive ? dq_word : 16'h0000;

   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   // R4
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && cfg_ctrl[CTL_BANK] && !cfg_ctrl[CTL_SRST]) |=> busy);

   // R3
   srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl[CTL_SRST] |=> !busy);

   // R2
   bank_off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_ctrl[CTL_BANK]) |=> !busy);

   // R11
   we_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n && !$past(nand_we_n)) |-> $stable(nand_dq_out));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (nand_we_n && nand_re_n && !nand_dq_oe && !nand_cle && !nand_ale));

endmodule

// File: tb/tb_nand_cycle_seq.sv
module tb_nand_cycle_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_ctrl = '0;
   logic [31:0] cfg_timing = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        req_write = 1'b0;
   logic        req_word = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        busy;
   logic [31:0] rd_data;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [15:0] nand_dq_out, nand_dq_in;

   always #2.5 clk = ~clk;

   nand_cycle_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_timing(cfg_timing),
      .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
      .req_word(req_word), .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
      .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
   );

   // device read model: beat k returns a fixed pattern
   function automatic logic [15:0] dev_val(input int k);
      return 16'hA5C3 + 16'(k) * 16'h1357;
   endfunction

   int rbeat = 0;
   always @(posedge nand_re_n) rbeat++;
   assign nand_dq_in = nand_re_n ? 16'h0000 : dev_val(rbeat);

   // pin monitor, sampled at the falling edge
   int n_busy, n_strobe, n_pre, n_cle, n_ale, n_oe, n_wb, n_clash;
   logic [15:0] wb [4];
   logic prev_we = 1'b1;

   task automatic clr_mon();
      n_busy = 0; n_strobe = 0; n_pre = 0; n_cle = 0; n_ale = 0; n_oe = 0; n_wb = 0;
      rbeat = 0;
   endtask

   always @(negedge clk) begin
      if (!nand_we_n && !nand_re_n) n_clash++;
      if (busy) begin
         n_busy++;
         if (!nand_we_n || !nand_re_n) n_strobe++;
         else if (n_strobe == 0) n_pre++;
         if (nand_cle) n_cle++;
         if (nand_ale) n_ale++;
         if (nand_dq_oe) n_oe++;
      end
      if (!nand_we_n && prev_we) begin
         if (n_wb < 4) wb[n_wb] = nand_dq_out;
         n_wb++;
      end
      prev_we = nand_we_n;
   end

   int checks = 0, fails = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   localparam logic [31:0] CTRL_BASE = (32'd1 << 2) | (32'd3 << 9) | (32'd5 << 13);
   localparam int TURN_CMD  = 4;   // tCLR = 3
   localparam int TURN_ADDR = 6;   // tAR = 5

   typedef struct packed {
      logic [1:0]  kind;
      logic        wr;
      logic        word;
      logic        w16;
      logic [31:0] tim;
      logic [31:0] dat;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b1, 1'b0, 1'b0, 32'h01010101, 32'h00000070},
      '{2'd2, 1'b0, 1'b0, 1'b0, 32'h01010101, 32'h00000000},
      '{2'd1, 1'b1, 1'b0, 1'b0, 32'h00020302, 32'h0000003C},
      '{2'd2, 1'b0, 1'b1, 1'b0, 32'h00020302, 32'h00000000},
      '{2'd2, 1'b0, 1'b1, 1'b0, 32'h00020302, 32'h00000000},
      '{2'd2, 1'b1, 1'b1, 1'b0, 32'h03000000, 32'hDEADBEEF},
      '{2'd2, 1'b1, 1'b1, 1'b1, 32'h02010203, 32'h12345678},
      '{2'd2, 1'b0, 1'b1, 1'b1, 32'h02010203, 32'h00000000},
      '{2'd0, 1'b0, 1'b0, 1'b1, 32'h00000000, 32'h00000090},
      '{2'd2, 1'b0, 1'b1, 1'b1, 32'h01030201, 32'h00000000},
      '{2'd2, 1'b1, 1'b0, 1'b1, 32'h01010101, 32'hABCDEF5A},
      '{2'd1, 1'b1, 1'b0, 1'b0, 32'h04020103, 32'h00000011},
      '{2'd2, 1'b0, 1'b0, 1'b1, 32'h01010101, 32'h00000000}
   };

   function automatic int at1(input logic [7:0] f);
      return (f == 0) ? 1 : int'(f);
   endfunction

   task automatic issue(input logic [1:0] k, input logic wr, input logic word, input logic [31:0] d);
      @(negedge clk);
      req_kind = k; req_write = wr; req_word = word; req_wdata = d; req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
   endtask

   int prev_kind = 0;   // 0 none/data, 1 command, 2 address
   logic done = 1'b0;

   initial begin
      clr_mon();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 strobes", {30'b0, nand_we_n, nand_re_n}, 32'h3);
      chk("R1 cle/ale/oe", {29'b0, nand_cle, nand_ale, nand_dq_oe}, 0);
      chk("R1 rd_data", rd_data, 0);
      chk("R2 ce_n off", 32'(nand_ce_n), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 bank disabled: request ignored
      clr_mon();
      issue(2'd0, 1'b1, 1'b0, 32'h70);
      repeat (4) @(negedge clk);
      chk("R2 ignored busy", 32'(n_busy), 0);
      chk("R2 ignored we", 32'(n_wb), 0);
      cfg_ctrl = CTRL_BASE;
      @(negedge clk);
      chk("R2 ce_n on", 32'(nand_ce_n), 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         int s = at1(t.tim[7:0]);
         int w = at1(t.tim[15:8]) + 1;
         int h = at1(t.tim[23:16]);
         int z = int'(t.tim[31:24]);
         logic isdata = t.kind[1];
         logic narrow = !isdata || !t.word;
         logic wr = !isdata || t.wr;
         int beats = narrow ? 1 : (t.w16 ? 2 : 4);
         int turn = (!wr && prev_kind == 1) ? TURN_CMD : (!wr && prev_kind == 2) ? TURN_ADDR : 0;
         int ebusy = turn + beats * (s + w + h) + z;
         logic [31:0] erd;
         cfg_ctrl = CTRL_BASE | (32'(t.w16) << 4);
         cfg_timing = t.tim;
         clr_mon();
         issue(t.kind, t.wr, t.word, t.dat);
         wait_idle();
         chk($sformatf("R10 R5 R6 busy v%0d", v), 32'(n_busy), 32'(ebusy));
         chk($sformatf("R5 R6 strobe v%0d", v), 32'(n_strobe), 32'(beats * w));
         chk($sformatf("R9 pre-strobe v%0d", v), 32'(n_pre), 32'(turn + s));
         chk($sformatf("R4 cle v%0d", v), 32'(n_cle), (t.kind == 2'd0) ? 32'(ebusy - z) : 0);
         chk($sformatf("R4 ale v%0d", v), 32'(n_ale), (t.kind == 2'd1) ? 32'(ebusy - z) : 0);
         chk($sformatf("R5 R8 oe v%0d", v), 32'(n_oe), wr ? 32'(beats * (s + w + h)) : 0);
         if (wr) begin
            chk($sformatf("R7 beats v%0d", v), 32'(n_wb), 32'(beats));
            for (int k = 0; k < beats; k++) begin
               logic [15:0] eb;
               if (narrow) eb = {8'h00, t.dat[7:0]};
               else if (t.w16) eb = t.dat[16*k +: 16];
               else eb = {8'h00, t.dat[8*k +: 8]};
               chk($sformatf("R7 R4 beat%0d v%0d", k, v), 32'(wb[k]), 32'(eb));
            end
         end else begin
            erd = '0;
            if (narrow) erd[7:0] = dev_val(0) & 16'h00FF;
            else if (t.w16) begin
               for (int k = 0; k < 2; k++) erd[16*k +: 16] = dev_val(k);
            end else begin
               for (int k = 0; k < 4; k++) erd[8*k +: 8] = dev_val(k) & 16'h00FF;
            end
            chk($sformatf("R8 rd_data v%0d", v), rd_data, erd);
         end
         prev_kind = (t.kind == 2'd0) ? 1 : (t.kind == 2'd1) ? 2 : 0;
      end
      chk("R11 we/re clash", 32'(n_clash), 0);

      // R10 request during busy is ignored
      cfg_ctrl = CTRL_BASE;
      cfg_timing = 32'h00101010;
      clr_mon();
      issue(2'd0, 1'b1, 1'b0, 32'hFF);
      repeat (3) @(negedge clk);
      issue(2'd1, 1'b1, 1'b0, 32'h22);
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R10 no ale", 32'(n_ale), 0);
      chk("R10 single beat", 32'(n_wb), 1);
      chk("R10 busy length", 32'(n_busy), 16 + 17 + 16);

      // R3 soft reset aborts a cycle and clears last kind
      cfg_timing = 32'h00004001;
      issue(2'd0, 1'b1, 1'b0, 32'h5A);
      repeat (5) @(negedge clk);
      chk("R3 in strobe", 32'(nand_we_n), 0);
      cfg_ctrl = CTRL_BASE | 32'h1;
      @(negedge clk);
      chk("R3 abort busy", 32'(busy), 0);
      chk("R3 abort we", 32'(nand_we_n), 1);
      clr_mon();
      issue(2'd2, 1'b0, 1'b0, 32'h0);
      repeat (3) @(negedge clk);
      chk("R3 ignored", 32'(n_busy), 0);
      cfg_ctrl = CTRL_BASE;
      cfg_timing = 32'h00010102;
      clr_mon();
      issue(2'd2, 1'b0, 1'b0, 32'h0);
      wait_idle();
      chk("R3 R9 no turn", 32'(n_pre), 2);
      chk("R3 R8 rd", rd_data, 32'(dev_val(0) & 16'h00FF));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule